// File: doc/BRIEF.md
# Superscalar Issue Grouping Unit

This unit sits at the front of an in-order integer pipeline that can issue up to three instructions per cycle. Each cycle it looks at the decoded descriptors in the first slots of the prefetch queue. It admits them into one issue group in program order and stops at the first slot that would break a grouping rule. The rules cover data-cache access, address-register reads, the control-flow close, load-result consumers and the two integer ALUs.

Each admitted ALU instruction gets one of two ALUs. The first ALU instruction of a group takes the primary ALU. A second ALU instruction takes the cascaded ALU, which sits in the late execute stage and can consume a same-group result. The unit keeps the cascaded destination of the group it issued last. When the head of the queue is a load or store that needs that register as an address, it signals a one-cycle bubble and issues nothing for that cycle. The queue front end uses the dequeue count to pop entries.

Top module: `grp_unit`

## Requirements
- R1: The group size never exceeds the number of slots (three) and only counts valid slots. An all-invalid queue gives size 0, and a queue whose slot 0 alone is valid gives at most 1.
- R2: Slots join strictly in order from slot 0. The first slot that is invalid or breaks a rule ends the group, even when a later slot would be legal.
- R3: Of the slot classes (0 none/other, 1 ALU, 2 load, 3 store), at most one load or store (class 2 or 3) is admitted per group.
- R4: A load or store whose address register (rs1 or rs2) is written by an earlier member of the same group does not join. ALU (1) and load (2) instructions write rd.
- R5: A slot with its next-PC flag set closes the group, so no later slot joins it.
- R6: The first admitted ALU instruction gets ALU code 1 (primary). A second ALU instruction, dependent on the first or not, gets code 2 (cascaded). Non-ALU and unissued slots get code 0. Slot k uses bits [2k+1:2k] of the ALU port.
- R7: When slot 0 is valid, is a load or store, and reads the cascaded-ALU destination of the group issued in the previous cycle, the bubble output is 1 and the group size is 0. The following cycle has no bubble from that same history.
- R8: An instruction that reads the destination of a load admitted earlier in the same group does not join. It starts the next group without a bubble.
- R9: Register 0 never creates a dependence, either inside a group or against the previous group.
- R10: The dequeue count always equals the group size. After reset no bubble history exists.
- R11: At most two ALU instructions join a group. A third one ends the group.
- R12: A load or store in slot 1 or 2 that reads the previous group's cascaded destination ends the group before itself. It raises no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_vld | input | NSLOT | Slot holds a decoded instruction |
| q_cls | input | 2*NSLOT | Class per slot: 0 other, 1 ALU, 2 load, 3 store |
| q_rs1 | input | 5*NSLOT | First source register per slot |
| q_rs2 | input | 5*NSLOT | Second source register per slot |
| q_rd | input | 5*NSLOT | Destination register per slot |
| q_npc | input | NSLOT | Slot writes the next-PC register (branch) |
| grp_size | output | 2 | Number of slots issued this cycle |
| deq_cnt | output | 2 | Entries to pop from the queue |
| alu_sel | output | 2*NSLOT | ALU choice per slot: 0 none, 1 primary, 2 cascaded |
| bubble | output | 1 | One-cycle bubble inserted before the head group |

## Verification
The bench targets four corner cases.

- A dependent ALU pair followed by a load that uses the pair's result as an address. A unit that forgot the history would issue the load at once instead of bubbling, and one that never cleared the history would bubble forever.
- Register 0 as both writer and reader. A design that compared raw register numbers would split groups and raise bubbles for no reason.
- Later slots after a break, such as a legal instruction behind a rejected one. Admitting it would reorder issue.
- Third-ALU, second-memory and branch-in-the-middle queues. These show up as a size one too large.

Random queues drawn from a small register range produce dense dependences. They cover the combinations that the directed cases leave out.

// File: rtl/gu_pkg.sv
package gu_pkg;
    localparam int REG_W = 5;

    typedef logic [REG_W-1:0] reg_t;

    typedef enum logic [1:0] {
        CL_OTHER = 2'd0,
        CL_ALU   = 2'd1,
        CL_LOAD  = 2'd2,
        CL_STORE = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        AU_NONE = 2'd0,
        AU_PRIM = 2'd1,
        AU_CASC = 2'd2
    } alu_e;

    typedef struct packed {
        logic vld;
        cls_e cls;
        reg_t rs1;
        reg_t rs2;
        reg_t rd;
        logic npc;
    } slot_t;

    typedef struct packed {
        logic vld;
        reg_t rd;
    } hist_t;

    function automatic logic is_mem(input cls_e c);
        return (c == CL_LOAD) || (c == CL_STORE);
    endfunction

    function automatic logic writes_rd(input slot_t s);
        return ((s.cls == CL_ALU) || (s.cls == CL_LOAD)) && (s.rd != '0);
    endfunction

    function automatic logic reads_reg(input slot_t s, input reg_t r);
        return (r != '0) && ((s.rs1 == r) || (s.rs2 == r));
    endfunction
endpackage

// File: rtl/gu_depmat.sv
module gu_depmat
    import gu_pkg::*;
#(
    parameter int NSLOT = 3
) (
    input  slot_t            slots  [NSLOT],
    input  hist_t            hist,
    output logic [NSLOT-1:0] wr_hit [NSLOT],
    output logic [NSLOT-1:0] ld_hit [NSLOT],
    output logic [NSLOT-1:0] pv_hit
);
    for (genvar k = 0; k < NSLOT; k++) begin : g_row
        for (genvar j = 0; j < NSLOT; j++) begin : g_col
            if (j < k) begin : g_older
                assign wr_hit[k][j] = writes_rd(slots[j]) && reads_reg(slots[k], slots[j].rd);
                assign ld_hit[k][j] = (slots[j].cls == CL_LOAD) && reads_reg(slots[k], slots[j].rd);
            end else begin : g_none
                assign wr_hit[k][j] = 1'b0;
                assign ld_hit[k][j] = 1'b0;
            end
        end
        assign pv_hit[k] = hist.vld && is_mem(slots[k].cls) && reads_reg(slots[k], hist.rd);
    end
endmodule

// File: rtl/gu_former.sv
module gu_former
    import gu_pkg::*;
#(
    parameter int NSLOT = 3,
    localparam int CW = $clog2(NSLOT + 1)
) (
    input  slot_t            slots  [NSLOT],
    input  logic [NSLOT-1:0] wr_hit [NSLOT],
    input  logic [NSLOT-1:0] ld_hit [NSLOT],
    input  logic [NSLOT-1:0] pv_hit,
    output logic [CW-1:0]    size,
    output alu_e             alu    [NSLOT],
    output logic             bubble,
    output hist_t            hist_nxt
);
    logic             open;
    logic             mem_seen;
    logic [1:0]       alu_cnt;
    logic [NSLOT-1:0] joined;
    logic             ok;

    always_comb begin
        bubble   = slots[0].vld && pv_hit[0];
        open     = !bubble;
        mem_seen = 1'b0;
        alu_cnt  = 2'd0;
        joined   = '0;
        size     = '0;
        hist_nxt = '0;
        ok       = 1'b0;
        for (int k = 0; k < NSLOT; k++) begin
            alu[k] = AU_NONE;
            ok = slots[k].vld && open;
            if (k > 0) begin
                if (is_mem(slots[k].cls) && mem_seen) ok = 1'b0;
                if (is_mem(slots[k].cls) && |(wr_hit[k] & joined)) ok = 1'b0;
                if (|(ld_hit[k] & joined)) ok = 1'b0;
                if ((slots[k].cls == CL_ALU) && (alu_cnt == 2'd2)) ok = 1'b0;
                if (pv_hit[k]) ok = 1'b0;
            end
            if (ok) begin
                joined[k] = 1'b1;
                size      = size + CW'(1);
                if (is_mem(slots[k].cls)) mem_seen = 1'b1;
                if (slots[k].cls == CL_ALU) begin
                    if (alu_cnt == 2'd0) begin
                        alu[k] = AU_PRIM;
                    end else begin
                        alu[k]       = AU_CASC;
                        hist_nxt.vld = 1'b1;
                        hist_nxt.rd  = slots[k].rd;
                    end
                    alu_cnt = alu_cnt + 2'd1;
                end
                if (slots[k].npc) open = 1'b0;
            end else begin
                open = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gu_hist.sv
module gu_hist
    import gu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  hist_t nxt,
    output hist_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end
endmodule

// File: rtl/grp_unit.sv
module grp_unit
    import gu_pkg::*;
#(
    parameter int NSLOT = 3,
    localparam int CW = $clog2(NSLOT + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSLOT-1:0]       q_vld,
    input  logic [2*NSLOT-1:0]     q_cls,
    input  logic [REG_W*NSLOT-1:0] q_rs1,
    input  logic [REG_W*NSLOT-1:0] q_rs2,
    input  logic [REG_W*NSLOT-1:0] q_rd,
    input  logic [NSLOT-1:0]       q_npc,
    output logic [CW-1:0]          grp_size,
    output logic [CW-1:0]          deq_cnt,
    output logic [2*NSLOT-1:0]     alu_sel,
    output logic                   bubble
);
    slot_t            slots  [NSLOT];
    alu_e             alu    [NSLOT];
    logic [NSLOT-1:0] wr_hit [NSLOT];
    logic [NSLOT-1:0] ld_hit [NSLOT];
    logic [NSLOT-1:0] pv_hit;
    hist_t            h_cur;
    hist_t            h_nxt;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign slots[k].vld = q_vld[k];
        assign slots[k].cls = cls_e'(q_cls[2*k +: 2]);
        assign slots[k].rs1 = q_rs1[REG_W*k +: REG_W];
        assign slots[k].rs2 = q_rs2[REG_W*k +: REG_W];
        assign slots[k].rd  = q_rd[REG_W*k +: REG_W];
        assign slots[k].npc = q_npc[k];
        assign alu_sel[2*k +: 2] = alu[k];
    end

    gu_depmat #(.NSLOT(NSLOT)) u_dep (
        .slots  (slots),
        .hist   (h_cur),
        .wr_hit (wr_hit),
        .ld_hit (ld_hit),
        .pv_hit (pv_hit)
    );

    gu_former #(.NSLOT(NSLOT)) u_form (
        .slots    (slots),
        .wr_hit   (wr_hit),
        .ld_hit   (ld_hit),
        .pv_hit   (pv_hit),
        .size     (grp_size),
        .alu      (alu),
        .bubble   (bubble),
        .hist_nxt (h_nxt)
    );

    gu_hist u_hist (
        .clk (clk),
        .rst (rst),
        .nxt (h_nxt),
        .cur (h_cur)
    );

    assign deq_cnt = grp_size;
endmodule

// File: rtl/gu_chk.sv
module gu_chk #(
    parameter int NSLOT = 3,
    localparam int CW = $clog2(NSLOT + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [NSLOT-1:0]   q_vld,
    input logic [2*NSLOT-1:0] q_cls,
    input logic [NSLOT-1:0]   q_npc,
    input logic [CW-1:0]      grp_size,
    input logic [CW-1:0]      deq_cnt,
    input logic [2*NSLOT-1:0] alu_sel,
    input logic               bubble
);
    int   mem_iss;
    int   casc_iss;
    int   vld_cnt;
    logic npc_mid;
    logic sel_outside;

    always_comb begin
        mem_iss = 0;
        casc_iss = 0;
        vld_cnt = 0;
        npc_mid = 1'b0;
        sel_outside = 1'b0;
        for (int k = 0; k < NSLOT; k++) begin
            if (q_vld[k]) vld_cnt++;
            if (k < int'(grp_size)) begin
                if (q_cls[2*k +: 2] >= 2'd2) mem_iss++;
                if (alu_sel[2*k +: 2] == 2'd2) casc_iss++;
                if (q_npc[k] && (k + 1 < int'(grp_size))) npc_mid = 1'b1;
            end else if (alu_sel[2*k +: 2] != 2'd0) begin
                sel_outside = 1'b1;
            end
        end
    end

    assert_size_le_valid_R1: assert property (@(posedge clk) disable iff (rst)
        int'(grp_size) <= vld_cnt);
    assert_no_sel_past_group_R2: assert property (@(posedge clk) disable iff (rst)
        !sel_outside);
    assert_one_mem_R3: assert property (@(posedge clk) disable iff (rst)
        mem_iss <= 1);
    assert_branch_last_R5: assert property (@(posedge clk) disable iff (rst)
        !npc_mid);
    assert_one_casc_R6: assert property (@(posedge clk) disable iff (rst)
        casc_iss <= 1);
    assert_bubble_empty_R7: assert property (@(posedge clk) disable iff (rst)
        bubble |-> (grp_size == '0));
    assert_bubble_once_R7: assert property (@(posedge clk) disable iff (rst)
        bubble |=> !bubble);
    assert_deq_match_R10: assert property (@(posedge clk) disable iff (rst)
        deq_cnt == grp_size);
endmodule

bind grp_unit gu_chk #(.NSLOT(NSLOT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .q_vld    (q_vld),
    .q_cls    (q_cls),
    .q_npc    (q_npc),
    .grp_size (grp_size),
    .deq_cnt  (deq_cnt),
    .alu_sel  (alu_sel),
    .bubble   (bubble)
);

// File: tb/grp_unit_tb.sv
module grp_unit_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic       v [3];
    logic [1:0] c [3];
    logic [4:0] a [3];
    logic [4:0] b [3];
    logic [4:0] d [3];
    logic       n [3];

    logic [2:0]  q_vld, q_npc;
    logic [5:0]  q_cls;
    logic [14:0] q_rs1, q_rs2, q_rd;
    logic [1:0]  grp_size, deq_cnt;
    logic [5:0]  alu_sel;
    logic        bubble;

    always_comb begin
        for (int k = 0; k < 3; k++) begin
            q_vld[k] = v[k];
            q_npc[k] = n[k];
            q_cls[2*k +: 2] = c[k];
            q_rs1[5*k +: 5] = a[k];
            q_rs2[5*k +: 5] = b[k];
            q_rd[5*k +: 5] = d[k];
        end
    end

    grp_unit u_dut (
        .clk(clk), .rst(rst), .q_vld(q_vld), .q_cls(q_cls), .q_rs1(q_rs1),
        .q_rs2(q_rs2), .q_rd(q_rd), .q_npc(q_npc), .grp_size(grp_size),
        .deq_cnt(deq_cnt), .alu_sel(alu_sel), .bubble(bubble)
    );

    int errors = 0;
    int checks = 0;
    logic       m_hv = 1'b0;
    logic [4:0] m_hd = '0;

    function automatic logic reads(input int k, input logic [4:0] r);
        return (r != 0) && (a[k] == r || b[k] == r);
    endfunction

    function automatic logic mem(input logic [1:0] cl);
        return cl == 2'd2 || cl == 2'd3;
    endfunction

    function automatic void model(output int sz, output logic [5:0] al, output logic bub,
                                  output logic nv, output logic [4:0] nd);
        logic stop, ok;
        int nalu;
        bub = v[0] && mem(c[0]) && m_hv && reads(0, m_hd);
        stop = bub;
        sz = 0; al = '0; nv = 1'b0; nd = '0; nalu = 0;
        for (int k = 0; k < 3; k++) begin
            if (!stop) begin
                ok = v[k];
                for (int j = 0; j < k; j++) begin
                    if (mem(c[k]) && mem(c[j])) ok = 1'b0;
                    if (mem(c[k]) && (c[j] == 2'd1 || c[j] == 2'd2) && reads(k, d[j])) ok = 1'b0;
                    if (c[j] == 2'd2 && reads(k, d[j])) ok = 1'b0;
                end
                if (k > 0 && c[k] == 2'd1 && nalu == 2) ok = 1'b0;
                if (k > 0 && mem(c[k]) && m_hv && reads(k, m_hd)) ok = 1'b0;
                if (ok) begin
                    sz++;
                    if (c[k] == 2'd1) begin
                        al[2*k +: 2] = (nalu == 0) ? 2'd1 : 2'd2;
                        if (nalu == 1) begin nv = 1'b1; nd = d[k]; end
                        nalu++;
                    end
                    if (n[k]) stop = 1'b1;
                end else begin
                    stop = 1'b1;
                end
            end
        end
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        int sz; logic [5:0] al; logic bub, nv; logic [4:0] nd;
        @(negedge clk);
        #1;
        model(sz, al, bub, nv, nd);
        chk(tag, "grp_size", int'(grp_size), sz);
        chk(tag, "deq_cnt(R10)", int'(deq_cnt), sz);
        chk(tag, "alu_sel", int'(alu_sel), int'(al));
        chk(tag, "bubble", int'(bubble), int'(bub));
        @(posedge clk);
        m_hv = nv; m_hd = nd;
        #1;
    endtask

    task automatic clr();
        for (int k = 0; k < 3; k++) begin
            v[k] = 0; c[k] = 0; a[k] = 0; b[k] = 0; d[k] = 0; n[k] = 0;
        end
    endtask

    task automatic put(input int k, input logic [1:0] cl, input logic [4:0] s1,
                       input logic [4:0] s2, input logic [4:0] rd, input logic br);
        v[k] = 1; c[k] = cl; a[k] = s1; b[k] = s2; d[k] = rd; n[k] = br;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(posedge clk);
        #1;
        chk("R10", "reset grp_size", int'(grp_size), 0);
        chk("R10", "reset bubble", int'(bubble), 0);
        rst = 1'b0;
        #1;

        clr(); step("R1 empty");
        clr(); put(0, 1, 1, 2, 3, 0); step("R1 single");
        clr(); put(0, 2, 1, 0, 5, 0); put(1, 3, 2, 0, 0, 0); step("R3 two mem");
        clr(); put(0, 1, 1, 2, 6, 0); put(1, 3, 6, 0, 0, 0); step("R4 addr dep");
        clr(); put(0, 0, 0, 0, 0, 1); put(1, 1, 1, 2, 3, 0); put(2, 1, 1, 2, 4, 0); step("R5 head branch");
        clr(); put(0, 1, 1, 2, 3, 0); put(1, 0, 0, 0, 0, 1); put(2, 1, 1, 2, 4, 0); step("R5 mid branch");
        clr(); put(0, 1, 1, 2, 3, 0); put(1, 1, 3, 5, 4, 0); put(2, 2, 4, 0, 3, 0); step("R6 cascade pair");
        clr(); put(0, 2, 4, 0, 3, 0); put(1, 1, 6, 3, 7, 0); step("R7 bubble");
        clr(); put(0, 2, 4, 0, 3, 0); put(1, 1, 6, 3, 7, 0); step("R8 load use");
        clr(); put(0, 1, 6, 3, 7, 0); step("R8 next group");
        clr(); put(0, 1, 1, 2, 0, 0); put(1, 1, 1, 2, 0, 0); put(2, 3, 0, 0, 0, 0); step("R9 r0 writer");
        clr(); put(0, 2, 0, 0, 8, 0); step("R9 no r0 bubble");
        clr(); put(0, 1, 1, 2, 3, 0); put(1, 1, 1, 2, 4, 0); put(2, 1, 1, 2, 5, 0); step("R11 three alu");
        clr(); put(0, 1, 1, 2, 9, 0); put(1, 2, 4, 0, 10, 0); step("R12 later mem");
        clr(); put(0, 1, 1, 2, 3, 0); put(1, 2, 1, 0, 5, 0); put(2, 2, 1, 0, 6, 0); step("R2 break");
        clr(); put(0, 0, 1, 2, 3, 0); put(1, 0, 1, 2, 3, 0); put(2, 0, 1, 2, 3, 0); step("R2 full");
        clr(); put(0, 1, 1, 2, 3, 0); put(2, 1, 1, 2, 4, 0); step("R2 hole");

        void'($urandom(32'd7321));
        for (int i = 0; i < 3000; i++) begin
            for (int k = 0; k < 3; k++) begin
                v[k] = ($urandom % 8) != 0;
                c[k] = 2'($urandom % 4);
                a[k] = 5'($urandom % 4);
                b[k] = 5'($urandom % 4);
                d[k] = 5'($urandom % 4);
                n[k] = ($urandom % 8) == 0;
            end
            step("R2 random");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule